// File: doc/BRIEF.md
# Burst Gain Ramp Controller

This block shapes the amplitude envelope of a burst transmission. A 128-entry table of 12-bit unsigned gain steps sits in front of a pair of sample multipliers, one for the in-phase lane and one for the quadrature lane. A table pointer climbs one entry per valid sample while the transmit-enable input is high, and stops at a programmable ramp length. It descends one entry per valid sample while transmit-enable is low, and stops at zero. The burst therefore fades in and out over the same number of samples and follows the same gain curve in both directions, which keeps spectral sidelobes under control.

The gain read at the current pointer scales both lanes equally, with 1.11 fixed-point weighting: 0x800 is unity, 0x001 is 2^-11 and 0x000 mutes the output. When the profile is switched off, the gain is unity and the pointer is held at zero. A freeze control keeps the last applied gain and holds the pointer still, so the table can be rewritten while samples continue to flow.

Top module: `burst_ramp_gain`

## Requirements
- R1: The table is written through `tbl_we`, `tbl_addr` (0 to 127) and `tbl_wdata`. A written entry is the gain applied to any sample presented at a later clock edge while the pointer sits on that entry.
- R2: Each output is round-half-up of `x*g/2048`, where `x` is the signed 16-bit input and `g` is the unsigned 12-bit gain. This is `floor((x*g + 1024) / 2048)`.
- R3: While `prof_on` is low and `freeze` is low, the gain is 0x800, so the output equals the input. While `prof_on` is low the pointer is forced to 0. After `prof_on` is raised again, the first sample uses entry 0.
- R4: While `prof_on` and `tx_on` are high and `freeze` is low, each valid sample moves the pointer one step toward `ramp_len` (7 bits). Once the pointer equals `ramp_len` it stays there.
- R5: While `prof_on` is high, `tx_on` is low and `freeze` is low, each valid sample moves the pointer one step down until it reaches 0.
- R6: If `tx_on` changes in the middle of a ramp, the pointer reverses direction from its current position.
- R7: The pointer moves only on cycles with `in_vld` high. Idle cycles change neither the pointer nor the outputs.
- R8: While `freeze` is high, the gain is the last gain applied to a non-frozen sample (0x800 after reset) and the pointer does not move. Table writes made during the freeze do not affect the output until the freeze is released.
- R9: The in-phase and quadrature lanes of a sample are scaled by the same gain.
- R10: `out_vld` rises one clock after `in_vld`. The outputs are registered and change only on a valid sample.
- R11: Table values above 0x800 give gain above 1.0. Results outside the signed 16-bit range saturate to 32767 or -32768.
- R12: After reset, `out_vld` is 0, both outputs are 0, the pointer is 0 and the frozen gain is 0x800.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 7 | Table write address |
| tbl_wdata | input | 12 | Gain value to write, 1.11 unsigned |
| ramp_len | input | 7 | Pointer ceiling while transmit is enabled |
| prof_on | input | 1 | Profile enable; low forces unity gain and pointer 0 |
| freeze | input | 1 | Hold last gain and pointer |
| tx_on | input | 1 | Transmit enable; its level sets the ramp direction |
| in_vld | input | 1 | Input sample strobe |
| in_i | input | 16 | In-phase sample, signed |
| in_q | input | 16 | Quadrature sample, signed |
| out_vld | output | 1 | Output sample strobe |
| out_i | output | 16 | Scaled in-phase sample |
| out_q | output | 16 | Scaled quadrature sample |

## Verification
The pointer cannot be read at the ports, but each table entry is loaded with a distinct value proportional to its address. The output on every valid sample therefore reveals the pointer position at that sample. A pointer that stepped wrongly, overshot the ramp length, moved on an idle cycle or failed to reverse would show as a wrong output value on the very next output strobe. A wrong frozen gain or a bad rounding step also shows within one sample, because rounding is swept over many gains and inputs, including half-way points and full-scale values.

// File: rtl/brg_pkg.sv
package brg_pkg;

   typedef enum logic [1:0] {
      STEP_STAY = 2'd0,
      STEP_UP   = 2'd1,
      STEP_DOWN = 2'd2
   } step_e;

   localparam int NLANE = 2;

   function automatic int unity_code(input int gain_w);
      return 1 << (gain_w - 1);
   endfunction

endpackage

// File: rtl/brg_profile_table.sv
module brg_profile_table #(
   parameter int GAIN_W = 12,
   parameter int DEPTH  = 128,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [GAIN_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [GAIN_W-1:0] rdata
);

   logic [GAIN_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         mem[waddr] <= wdata;
      end
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/brg_ramp_ptr.sv
module brg_ramp_ptr import brg_pkg::*; #(
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              freeze,
   input  logic              step_ok,
   input  logic              tx_on,
   input  logic [ADDR_W-1:0] ceiling,
   output logic [ADDR_W-1:0] ptr
);

   logic [ADDR_W-1:0] target;
   step_e             step;

   assign target = tx_on ? ceiling : '0;

   always_comb begin
      step = STEP_STAY;
      if (step_ok && !freeze) begin
         if (ptr < target) begin
            step = STEP_UP;
         end else if (ptr > target) begin
            step = STEP_DOWN;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !enable) begin
         ptr <= '0;
      end else begin
         case (step)
            STEP_UP:   ptr <= ptr + ADDR_W'(1);
            STEP_DOWN: ptr <= ptr - ADDR_W'(1);
            default:   ptr <= ptr;
         endcase
      end
   end

endmodule

// File: rtl/brg_lane_scaler.sv
module brg_lane_scaler #(
   parameter int DATA_W   = 16,
   parameter int GAIN_W   = 12,
   parameter bit ROUND_EN = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     vld,
   input  logic signed [DATA_W-1:0] din,
   input  logic [GAIN_W-1:0]        gain,
   output logic signed [DATA_W-1:0] dout
);

   localparam int PW = DATA_W + GAIN_W + 1;
   localparam int SH = GAIN_W - 1;
   localparam logic signed [PW:0] MAXV = $signed((PW+1)'((64'd1 << (DATA_W - 1)) - 64'd1));
   localparam logic signed [PW:0] MINV = -MAXV - $signed((PW+1)'(1));

   logic signed [GAIN_W:0] gain_s;
   logic signed [PW-1:0]   prod;
   logic signed [PW:0]     bias;
   logic signed [PW:0]     summed;
   logic signed [PW:0]     shifted;
   logic signed [DATA_W-1:0] clamped;

   assign gain_s = $signed({1'b0, gain});
   assign prod   = PW'(din) * PW'(gain_s);

   generate
      if (ROUND_EN) begin : g_round
         assign bias = $signed((PW+1)'(64'd1 << (SH - 1)));
      end else begin : g_trunc
         assign bias = '0;
      end
   endgenerate

   assign summed  = {prod[PW-1], prod} + bias;
   assign shifted = summed >>> SH;

   always_comb begin
      if (shifted > MAXV) begin
         clamped = MAXV[DATA_W-1:0];
      end else if (shifted < MINV) begin
         clamped = MINV[DATA_W-1:0];
      end else begin
         clamped = shifted[DATA_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dout <= '0;
      end else if (vld) begin
         dout <= clamped;
      end
   end

endmodule

// File: rtl/burst_ramp_gain.sv
module burst_ramp_gain import brg_pkg::*; #(
   parameter int DATA_W   = 16,
   parameter int GAIN_W   = 12,
   parameter int DEPTH    = 128,
   parameter bit ROUND_EN = 1'b1,
   localparam int ADDR_W  = $clog2(DEPTH)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     tbl_we,
   input  logic [ADDR_W-1:0]        tbl_addr,
   input  logic [GAIN_W-1:0]        tbl_wdata,
   input  logic [ADDR_W-1:0]        ramp_len,
   input  logic                     prof_on,
   input  logic                     freeze,
   input  logic                     tx_on,
   input  logic                     in_vld,
   input  logic signed [DATA_W-1:0] in_i,
   input  logic signed [DATA_W-1:0] in_q,
   output logic                     out_vld,
   output logic signed [DATA_W-1:0] out_i,
   output logic signed [DATA_W-1:0] out_q
);

   localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(unity_code(GAIN_W));

   initial begin
      assert (GAIN_W >= 2) else $error("GAIN_W must be at least 2");
      assert (DATA_W >= 2 && DATA_W <= 32) else $error("DATA_W out of range");
      assert (DEPTH == (1 << ADDR_W)) else $error("DEPTH must be a power of two");
   end

   logic [ADDR_W-1:0] ptr_q;
   logic [GAIN_W-1:0] tbl_gain;
   logic [GAIN_W-1:0] applied_gain;
   logic [GAIN_W-1:0] last_gain_q;

   brg_profile_table #(.GAIN_W(GAIN_W), .DEPTH(DEPTH)) u_table (
      .clk   (clk),
      .we    (tbl_we),
      .waddr (tbl_addr),
      .wdata (tbl_wdata),
      .raddr (ptr_q),
      .rdata (tbl_gain)
   );

   brg_ramp_ptr #(.ADDR_W(ADDR_W)) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (prof_on),
      .freeze  (freeze),
      .step_ok (in_vld),
      .tx_on   (tx_on),
      .ceiling (ramp_len),
      .ptr     (ptr_q)
   );

   always_comb begin
      if (freeze) begin
         applied_gain = last_gain_q;
      end else if (prof_on) begin
         applied_gain = tbl_gain;
      end else begin
         applied_gain = UNITY;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_gain_q <= UNITY;
      end else if (in_vld && !freeze) begin
         last_gain_q <= applied_gain;
      end
   end

   logic signed [DATA_W-1:0] lane_in  [NLANE];
   logic signed [DATA_W-1:0] lane_out [NLANE];

   assign lane_in[0] = in_i;
   assign lane_in[1] = in_q;

   generate
      for (genvar ln = 0; ln < NLANE; ln++) begin : g_lane
         brg_lane_scaler #(
            .DATA_W   (DATA_W),
            .GAIN_W   (GAIN_W),
            .ROUND_EN (ROUND_EN)
         ) u_scale (
            .clk   (clk),
            .rst_n (rst_n),
            .vld   (in_vld),
            .din   (lane_in[ln]),
            .gain  (applied_gain),
            .dout  (lane_out[ln])
         );
      end
   endgenerate

   assign out_i = lane_out[0];
   assign out_q = lane_out[1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_vld <= 1'b0;
      end else begin
         out_vld <= in_vld;
      end
   end

endmodule

// File: rtl/brg_checker.sv
module brg_checker #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 7
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     prof_on,
   input logic                     freeze,
   input logic                     tx_on,
   input logic                     in_vld,
   input logic signed [DATA_W-1:0] in_i,
   input logic signed [DATA_W-1:0] in_q,
   input logic [ADDR_W-1:0]        ramp_len,
   input logic                     out_vld,
   input logic signed [DATA_W-1:0] out_i,
   input logic signed [DATA_W-1:0] out_q,
   input logic [ADDR_W-1:0]        ptr
);

   AST_PTR_ZERO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !prof_on |=> (ptr == '0)); // R3

   AST_UNITY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && !prof_on && !freeze) |=> (out_i == $past(in_i) && out_q == $past(in_q))); // R3

   AST_RAMP_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (prof_on && !freeze && in_vld && tx_on && ptr < ramp_len) |=> (ptr == $past(ptr) + ADDR_W'(1))); // R4

   AST_RAMP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      (prof_on && in_vld && tx_on && ptr == ramp_len) |=> (ptr == $past(ptr))); // R4

   AST_RAMP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (prof_on && !freeze && in_vld && !tx_on && ptr != '0) |=> (ptr == $past(ptr) - ADDR_W'(1))); // R5

   AST_IDLE_PTR: assert property (@(posedge clk) disable iff (!rst_n)
      (prof_on && !in_vld) |=> $stable(ptr)); // R7

   AST_IDLE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> ($stable(out_i) && $stable(out_q))); // R7

   AST_FREEZE_PTR: assert property (@(posedge clk) disable iff (!rst_n)
      (prof_on && freeze) |=> $stable(ptr)); // R8

   AST_SAME_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && in_i == in_q) |=> (out_i == out_q)); // R9

   AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> out_vld); // R10

endmodule

bind burst_ramp_gain brg_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .prof_on  (prof_on),
   .freeze   (freeze),
   .tx_on    (tx_on),
   .in_vld   (in_vld),
   .in_i     (in_i),
   .in_q     (in_q),
   .ramp_len (ramp_len),
   .out_vld  (out_vld),
   .out_i    (out_i),
   .out_q    (out_q),
   .ptr      (ptr_q)
);

// File: tb/burst_ramp_gain_bench.sv
module burst_ramp_gain_bench;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              tbl_we = 1'b0;
   logic [6:0]        tbl_addr = '0;
   logic [11:0]       tbl_wdata = '0;
   logic [6:0]        ramp_len = '0;
   logic              prof_on = 1'b0;
   logic              freeze = 1'b0;
   logic              tx_on = 1'b0;
   logic              in_vld = 1'b0;
   logic signed [15:0] in_i = '0;
   logic signed [15:0] in_q = '0;
   logic              out_vld;
   logic signed [15:0] out_i;
   logic signed [15:0] out_q;

   burst_ramp_gain u_burst_ramp_gain (
      .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
      .tbl_wdata(tbl_wdata), .ramp_len(ramp_len), .prof_on(prof_on),
      .freeze(freeze), .tx_on(tx_on), .in_vld(in_vld), .in_i(in_i),
      .in_q(in_q), .out_vld(out_vld), .out_i(out_i), .out_q(out_q)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   int m_ram [128];
   int m_ptr  = 0;
   int m_last = 2048;
   int m_len  = 0;
   bit m_en   = 1'b0;
   bit m_hold = 1'b0;
   bit m_tx   = 1'b0;

   task automatic check(input string tag, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int scale(input int x, input int g);
      longint p;
      p = longint'(x) * longint'(g) + 64'sd1024;
      p = p >>> 11;
      if (p > 32767) p = 32767;
      if (p < -32768) p = -32768;
      return int'(p);
   endfunction

   task automatic wr(input int a, input int v);
      @(negedge clk);
      tbl_we = 1'b1; tbl_addr = 7'(a); tbl_wdata = 12'(v);
      @(negedge clk);
      tbl_we = 1'b0;
      m_ram[a] = v;
   endtask

   task automatic ctrl(input bit en, input bit hd, input bit tx, input int len);
      @(negedge clk);
      prof_on = en; freeze = hd; tx_on = tx; ramp_len = 7'(len);
      m_en = en; m_hold = hd; m_tx = tx; m_len = len;
      if (!en) m_ptr = 0;
   endtask

   task automatic send(input string tag, input int xi, input int xq);
      int g, tgt, ei, eq;
      @(negedge clk);
      in_i = 16'(xi); in_q = 16'(xq); in_vld = 1'b1;
      g = m_hold ? m_last : (m_en ? m_ram[m_ptr] : 2048);
      if (!m_hold) m_last = g;
      ei = scale(xi, g);
      eq = scale(xq, g);
      if (m_en && !m_hold) begin
         tgt = m_tx ? m_len : 0;
         if (m_ptr < tgt) m_ptr++;
         else if (m_ptr > tgt) m_ptr--;
      end
      @(negedge clk);
      in_vld = 1'b0;
      check({tag, " out_vld"}, int'(out_vld), 1);
      check({tag, " I"}, int'(out_i), ei);
      check({tag, " Q"}, int'(out_q), eq);
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12: reset state
      check("R12 out_vld", int'(out_vld), 0);
      check("R12 out_i", int'(out_i), 0);
      check("R12 out_q", int'(out_q), 0);

      // R3: profile off passes samples at unity
      send("R3 unity a", 12345, -12345);
      send("R3 unity b", 32767, -32768);
      send("R3 unity c", -1, 1);
      // R10: out_vld drops after an idle cycle
      @(negedge clk);
      check("R10 out_vld idle", int'(out_vld), 0);

      // R1: load every entry with a value that encodes its address
      for (int a = 0; a < 128; a++) wr(a, a * 16);

      // R4: ramp up to length 10, then sit there
      ctrl(1'b1, 1'b0, 1'b0, 10);
      send("R5 rest at zero", 16384, -12345);
      ctrl(1'b1, 1'b0, 1'b1, 10);
      for (int k = 0; k < 14; k++) send("R4 ramp up", 16384, -12345);
      // R7: idle cycles leave pointer and outputs alone
      repeat (6) @(negedge clk);
      check("R7 idle out_i", int'(out_i), scale(16384, m_ram[10]));
      send("R7 after idle", 20000, 20000);

      // R5: ramp down to zero, then sit there
      ctrl(1'b1, 1'b0, 1'b0, 10);
      for (int k = 0; k < 13; k++) send("R5 ramp down", 30000, -7777);

      // R6: reversals mid ramp
      ctrl(1'b1, 1'b0, 1'b1, 20);
      for (int k = 0; k < 6; k++) send("R6 up", 9999, -9999);
      ctrl(1'b1, 1'b0, 1'b0, 20);
      for (int k = 0; k < 3; k++) send("R6 down", 9999, -9999);
      ctrl(1'b1, 1'b0, 1'b1, 20);
      for (int k = 0; k < 4; k++) send("R6 up again", 9999, -9999);

      // R8: freeze, rewrite table in place, gain stays
      ctrl(1'b1, 1'b1, 1'b1, 20);
      wr(m_ptr, 4095);
      wr(m_ptr + 1, 100);
      for (int k = 0; k < 3; k++) send("R8 frozen", 25000, -25000);
      ctrl(1'b1, 1'b0, 1'b1, 20);
      // R11: new entry above 1.0 saturates both lanes
      send("R11 saturate", 32767, -32768);
      send("R1 rewritten entry", 25000, -25000);

      // R3: disabling resets the pointer, re-enable starts at entry 0
      ctrl(1'b0, 1'b0, 1'b1, 20);
      send("R3 off", 777, -777);
      ctrl(1'b1, 1'b0, 1'b0, 20);
      send("R3 restart entry 0", 30000, 30000);

      // R8: freeze with profile off keeps last gain
      ctrl(1'b1, 1'b1, 1'b0, 20);
      ctrl(1'b0, 1'b1, 1'b0, 20);
      send("R8 frozen while off", 5000, -5000);

      // R2 R9: rounding sweep over gains and inputs at entry 0
      ctrl(1'b1, 1'b0, 1'b0, 0);
      for (int g = 0; g <= 2048; g += 65) begin
         wr(0, g);
         send("R2 sweep a", -32768, 32767);
         send("R2 sweep b", -3, 3);
         send("R2 sweep c", -1, 1);
         send("R9 sweep d", 1001, 1001);
         send("R2 sweep e", -12345, 4567);
      end
      wr(0, 1024);
      send("R2 half tie", 1, -1);
      wr(0, 2048);
      send("R2 unity entry", -32768, 32767);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule